// File: doc/BRIEF.md
# Adaptive Delta-Sigma Step-Size Controller

This block is the digital adaptation stage of a first-order, single-bit delta-sigma modulator. Each modulator clock the comparator decision arrives with a valid strobe. The block keeps a short history of earlier decisions and looks for two patterns in that history. A run of identical decisions means the input is outgrowing the feedback amplitude. A strictly alternating sequence means the feedback is larger than it needs to be.

A pointer into a geometric table of step magnitudes reacts to these patterns. It jumps three entries toward large steps after a run and creeps one entry toward small steps after alternation, so growth is much faster than decay. The selected magnitude, with the decision as its sign, is registered into a sign-magnitude word for an external feedback DAC. The plain magnitude is registered alongside it for downstream gain control.

Top module: `adsm_step_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears fb_valid, fb_word and fb_mag to zero, places the table pointer at its last entry (index 99, magnitude 1) and empties the decision history.
- R2: Table entry k, for k from 0 to 99, equals round(255 × 0.9391^k). Entry 0 is 255 and entry 99 is 1.
- R3: The pointer stays within 0..99. A move of three toward 0 from an index below 3 lands on 0, and a move of one past 99 stays at 99.
- R4: When the current decision and the four preceding valid decisions are all equal, the pointer decreases by 3, which increases the step.
- R5: When the current decision and the three preceding valid decisions alternate (each differs from the one before it), the pointer increases by 1, which decreases the step.
- R6: For any other pattern of the current and preceding decisions, the pointer does not change.
- R7: Neither rule can fire until at least four valid decisions have been captured since reset, so the current decision is at least the fifth.
- R8: One clock after a valid decision is sampled, fb_valid is 1 and fb_mag holds the table entry at the pointer value after that decision's update. fb_word[7:0] equals the same magnitude, and fb_word[8] is 1 when dec_bit was 0 (negative) and 0 when dec_bit was 1 (positive).
- R9: A cycle with dec_valid low changes neither the pointer nor the history. fb_word and fb_mag hold their values, and fb_valid is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | dec_bit carries a new comparator decision this cycle |
| dec_bit | input | 1 | Comparator decision, 1 = positive, 0 = negative |
| fb_valid | output | 1 | Registered outputs were updated at the last edge |
| fb_word | output | 9 | Sign-magnitude feedback word, bit 8 sign (1 = negative) |
| fb_mag | output | 8 | Current step magnitude |

## Verification
The bench builds the block with its default parameters: 8-bit magnitude, a 100-entry table with ratio 0.9391, a run length of five and an alternation length of four. With a jump of three, about three dozen equal decisions drive the pointer from 99 down to 0. Roughly a hundred alternating decisions bring it back. Both saturation ends, and the clamping of a jump that would overshoot 0, are therefore exercised within a few hundred cycles. The stimulus also mixes short runs with alternating stretches and gaps in the valid strobe, so the hold and warm-up behaviour is observed between adaptation steps.

// File: rtl/adsm_pkg.sv
package adsm_pkg;

  localparam int FIX_FRAC = 40;

  // Magnitude of table entry k: round((2^mag_w - 1) * (num/den)^k),
  // evaluated in fixed point with FIX_FRAC fractional bits.
  function automatic logic [63:0] step_value(int k, int mag_w, int num, int den);
    logic [63:0] acc;
    acc = ((64'd1 << mag_w) - 64'd1) << FIX_FRAC;
    for (int i = 0; i < k; i++) begin
      acc = (acc * 64'(num)) / 64'(den);
    end
    return (acc + (64'd1 << (FIX_FRAC - 1))) >> FIX_FRAC;
  endfunction

  // Saturating pointer update: a run moves toward 0, alternation toward last.
  function automatic int next_index(int cur, logic run, logic alt,
                                    int fast, int slow, int last);
    int r;
    r = cur;
    if (run) begin
      r = (cur - fast < 0) ? 0 : cur - fast;
    end else if (alt) begin
      r = (cur + slow > last) ? last : cur + slow;
    end
    return r;
  endfunction

endpackage

// File: rtl/adsm_dec_history.sv
module adsm_dec_history #(
  parameter int DEPTH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             bit_in,
  output logic [DEPTH-1:0] hist,
  output logic             full
);
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      fill_q <= '0;
    end else if (push) begin
      if (DEPTH > 1) begin
        hist <= {hist[DEPTH-2:0], bit_in};
      end else begin
        hist <= DEPTH'(bit_in);
      end
      if (int'(fill_q) < DEPTH) begin
        fill_q <= fill_q + FILL_W'(1);
      end
    end
  end

  assign full = (int'(fill_q) == DEPTH);
endmodule

// File: rtl/adsm_pattern_det.sv
module adsm_pattern_det #(
  parameter int RUN_LEN = 5,
  parameter int ALT_LEN = 4,
  parameter int DEPTH   = 4
) (
  input  logic             cur,
  input  logic             enable,
  input  logic [DEPTH-1:0] hist,
  output logic             run_hit,
  output logic             alt_hit
);
  logic [DEPTH:0]     win;
  logic [RUN_LEN-2:0] same;
  logic [ALT_LEN-2:0] flip;

  // win[0] is the current decision, win[i] the i-th older one
  assign win = {hist, cur};

  for (genvar i = 1; i < RUN_LEN; i++) begin : g_same
    assign same[i-1] = (win[i] == win[0]);
  end

  for (genvar i = 1; i < ALT_LEN; i++) begin : g_flip
    assign flip[i-1] = (win[i] != win[i-1]);
  end

  assign run_hit = enable & (&same);
  assign alt_hit = enable & (&flip);
endmodule

// File: rtl/adsm_step_rom.sv
module adsm_step_rom #(
  parameter int MAG_W     = 8,
  parameter int TAB_LEN   = 100,
  parameter int RATIO_NUM = 9391,
  parameter int RATIO_DEN = 10000,
  localparam int IDX_W    = $clog2(TAB_LEN)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag
);
  import adsm_pkg::*;

  logic [MAG_W-1:0] tab [TAB_LEN];

  for (genvar g = 0; g < TAB_LEN; g++) begin : g_ent
    assign tab[g] = MAG_W'(step_value(g, MAG_W, RATIO_NUM, RATIO_DEN));
  end

  always_comb begin
    if (int'(idx) < TAB_LEN) mag = tab[idx];
    else                     mag = tab[TAB_LEN-1];
  end
endmodule

// File: rtl/adsm_index_reg.sv
module adsm_index_reg #(
  parameter int TAB_LEN   = 100,
  parameter int FAST_STEP = 3,
  parameter int SLOW_STEP = 1,
  localparam int IDX_W    = $clog2(TAB_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             run_hit,
  input  logic             alt_hit,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_d
);
  import adsm_pkg::*;

  always_comb begin
    idx_d = idx_q;
    if (adv) begin
      idx_d = IDX_W'(next_index(int'(idx_q), run_hit, alt_hit,
                                FAST_STEP, SLOW_STEP, TAB_LEN - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= IDX_W'(TAB_LEN - 1);
    else     idx_q <= idx_d;
  end
endmodule

// File: rtl/adsm_step_ctrl.sv
module adsm_step_ctrl #(
  parameter int MAG_W     = 8,
  parameter int TAB_LEN   = 100,
  parameter int RATIO_NUM = 9391,
  parameter int RATIO_DEN = 10000,
  parameter int RUN_LEN   = 5,
  parameter int ALT_LEN   = 4,
  parameter int FAST_STEP = 3,
  parameter int SLOW_STEP = 1,
  localparam int IDX_W    = $clog2(TAB_LEN),
  localparam int HIST_D   = ((RUN_LEN > ALT_LEN) ? RUN_LEN : ALT_LEN) - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dec_valid,
  input  logic           dec_bit,
  output logic           fb_valid,
  output logic [MAG_W:0] fb_word,
  output logic [MAG_W-1:0] fb_mag
);
  logic [HIST_D-1:0] hist;
  logic              hist_full;
  logic              run_hit;
  logic              alt_hit;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_d;
  logic [MAG_W-1:0]  mag_next;

  adsm_dec_history #(.DEPTH(HIST_D)) hist_i (
    .clk    (clk),
    .rst    (rst),
    .push   (dec_valid),
    .bit_in (dec_bit),
    .hist   (hist),
    .full   (hist_full)
  );

  adsm_pattern_det #(.RUN_LEN(RUN_LEN), .ALT_LEN(ALT_LEN), .DEPTH(HIST_D)) det_i (
    .cur     (dec_bit),
    .enable  (dec_valid & hist_full),
    .hist    (hist),
    .run_hit (run_hit),
    .alt_hit (alt_hit)
  );

  adsm_index_reg #(.TAB_LEN(TAB_LEN), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)) idx_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (dec_valid),
    .run_hit (run_hit),
    .alt_hit (alt_hit),
    .idx_q   (idx_q),
    .idx_d   (idx_d)
  );

  adsm_step_rom #(.MAG_W(MAG_W), .TAB_LEN(TAB_LEN),
                  .RATIO_NUM(RATIO_NUM), .RATIO_DEN(RATIO_DEN)) rom_i (
    .idx (idx_d),
    .mag (mag_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_valid <= 1'b0;
      fb_word  <= '0;
      fb_mag   <= '0;
    end else begin
      fb_valid <= dec_valid;
      if (dec_valid) begin
        fb_word <= {~dec_bit, mag_next};
        fb_mag  <= mag_next;
      end
    end
  end
endmodule

// File: rtl/adsm_step_ctrl_chk.sv
module adsm_step_ctrl_chk #(
  parameter int MAG_W     = 8,
  parameter int TAB_LEN   = 100,
  parameter int FAST_STEP = 3,
  parameter int SLOW_STEP = 1,
  localparam int IDX_W    = $clog2(TAB_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic             dec_bit,
  input logic             fb_valid,
  input logic [MAG_W:0]   fb_word,
  input logic [MAG_W-1:0] fb_mag,
  input logic             run_hit,
  input logic             alt_hit,
  input logic [IDX_W-1:0] idx_q
);
  // R3: pointer never leaves the table
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) <= TAB_LEN - 1);

  // R4: a run moves the pointer toward large steps, clamped at 0
  a_r4_run_steps_down: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && run_hit) |=>
      int'(idx_q) == ((int'($past(idx_q)) >= FAST_STEP) ?
                      int'($past(idx_q)) - FAST_STEP : 0));

  // R5: alternation moves the pointer toward small steps, clamped at the end
  a_r5_alt_steps_up: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && alt_hit) |=>
      int'(idx_q) == ((int'($past(idx_q)) + SLOW_STEP > TAB_LEN - 1) ?
                      TAB_LEN - 1 : int'($past(idx_q)) + SLOW_STEP));

  // R6: other patterns leave the pointer alone
  a_r6_no_pattern_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !run_hit && !alt_hit) |=> $stable(idx_q));

  // R4/R5: the two patterns can never coincide
  a_r4_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(run_hit && alt_hit));

  // R8: sign follows the sampled decision, magnitude copies fb_mag
  a_r8_sign_tracks_bit: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> (fb_word[MAG_W] == !$past(dec_bit)) && fb_valid);

  a_r8_word_mag_agree: assert property (@(posedge clk) disable iff (rst)
    fb_valid |-> (fb_word[MAG_W-1:0] == fb_mag) && (fb_mag != '0));

  // R9: idle cycles freeze pointer and outputs
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> $stable(idx_q) && $stable(fb_word) && $stable(fb_mag) && !fb_valid);
endmodule

bind adsm_step_ctrl adsm_step_ctrl_chk #(
  .MAG_W(MAG_W), .TAB_LEN(TAB_LEN), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .dec_valid (dec_valid),
  .dec_bit   (dec_bit),
  .fb_valid  (fb_valid),
  .fb_word   (fb_word),
  .fb_mag    (fb_mag),
  .run_hit   (run_hit),
  .alt_hit   (alt_hit),
  .idx_q     (idx_q)
);

// File: tb/adsm_step_ctrl_tb_top.sv
module adsm_step_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic       dec_bit = 1'b0;
  logic       fb_valid;
  logic [8:0] fb_word;
  logic [7:0] fb_mag;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  adsm_step_ctrl dut_i (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_bit(dec_bit),
    .fb_valid(fb_valid), .fb_word(fb_word), .fb_mag(fb_mag)
  );

  // Stimulus segments: starting bit, alternate flag, length
  typedef struct packed { logic first; logic alternate; logic [7:0] len; } seg_t;
  localparam seg_t SEGS [10] = '{
    '{1'b1, 1'b0, 8'd5},   '{1'b1, 1'b1, 8'd6},   '{1'b0, 1'b0, 8'd40},
    '{1'b0, 1'b1, 8'd30},  '{1'b1, 1'b0, 8'd7},   '{1'b1, 1'b1, 8'd3},
    '{1'b0, 1'b0, 8'd3},   '{1'b1, 1'b1, 8'd120}, '{1'b1, 1'b0, 8'd4},
    '{1'b0, 1'b1, 8'd9}
  };

  // Reference model state
  int  ref_tab [100];
  int  m_idx;
  int  m_fill;
  bit  m_prev [4];

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idx = 99;
    m_fill = 0;
    for (int i = 0; i < 4; i++) m_prev[i] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    dec_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Drive one decision, advance the model, compare one edge later
  task automatic decide(bit b);
    bit run, alt;
    string tag;
    run = (m_fill >= 4) && (b == m_prev[0]) && (b == m_prev[1]) &&
          (b == m_prev[2]) && (b == m_prev[3]);
    alt = (m_fill >= 4) && (b != m_prev[0]) && (m_prev[0] != m_prev[1]) &&
          (m_prev[1] != m_prev[2]);
    if (run) begin
      m_idx = m_idx - 3;
      if (m_idx < 0) m_idx = 0;
      tag = "R4";
    end else if (alt) begin
      m_idx = m_idx + 1;
      if (m_idx > 99) m_idx = 99;
      tag = "R5";
    end else begin
      tag = (m_fill < 4) ? "R7" : "R6";
    end
    for (int i = 3; i > 0; i--) m_prev[i] = m_prev[i-1];
    m_prev[0] = b;
    if (m_fill < 4) m_fill++;
    @(negedge clk);
    dec_valid = 1'b1;
    dec_bit = b;
    @(posedge clk);
    #1;
    check({tag, " mag"}, int'(fb_mag), ref_tab[m_idx]);
    check("R8 word", int'(fb_word), (b ? 0 : 256) + ref_tab[m_idx]);
    check("R8 valid", int'(fb_valid), 1);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  initial begin
    real r;
    r = 255.0;
    for (int k = 0; k < 100; k++) begin
      ref_tab[k] = int'($rtoi(r + 0.5));
      r = r * 0.9391;
    end
    model_reset();

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", int'(fb_valid), 0);
    check("R1 word", int'(fb_word), 0);
    check("R1 mag", int'(fb_mag), 0);
    check("R2 entry0", ref_tab[0], 255);
    check("R2 entry99", ref_tab[99], 1);
    do_reset();

    // First decision after reset shows the minimum step (R1)
    decide(1'b1);
    check("R1 min step", int'(fb_mag), 1);

    // Vector walk over the segment table
    for (int s = 0; s < 10; s++) begin
      for (int j = 0; j < int'(SEGS[s].len); j++) begin
        decide(SEGS[s].alternate ? (SEGS[s].first ^ j[0]) : SEGS[s].first);
      end
    end

    // R3 low end: long run reaches index 0 and stays there
    do_reset();
    for (int j = 0; j < 45; j++) decide(1'b0);
    check("R3 low saturate", int'(fb_mag), 255);
    check("R2 largest", int'(fb_word), 256 + 255);
    decide(1'b0);
    check("R3 stays at 0", int'(fb_mag), 255);

    // R3 high end: alternation climbs to index 99 and stays there
    for (int j = 0; j < 110; j++) decide(j[0]);
    check("R3 high saturate", int'(fb_mag), 1);

    // R7 and R1: reset clears history, four equal decisions do not fire
    for (int j = 0; j < 20; j++) decide(1'b1);
    do_reset();
    for (int j = 0; j < 4; j++) begin
      decide(1'b1);
      check("R7 warm-up", int'(fb_mag), 1);
    end

    // R9: idle cycles hold outputs and history
    do_reset();
    for (int j = 0; j < 4; j++) decide(1'b1);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      dec_valid = 1'b0;
      dec_bit = j[0];
      @(posedge clk);
      #1;
      check("R9 valid low", int'(fb_valid), 0);
      check("R9 word held", int'(fb_word), 1);
    end
    decide(1'b1);
    check("R9 history kept", int'(fb_mag), ref_tab[96]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule